// File: doc/BRIEF.md
# Latch-or-Register Bus Driver

This block passes a wide data bus from an input side to an output side through one storage stage. A mode input selects how that stage behaves. With the mode input high the stage is transparent and the output follows the input bus directly. With the mode input low the stage is an edge-triggered register that captures the input bus on each rising edge of a separate capture-clock input, and holds its value between edges.

The capture clock, mode input and active-low output enable are asynchronous device-level signals. The block samples them on a free-running system clock through a synchronizer chain, and it detects rising capture-clock edges by comparing the synchronized level between consecutive system cycles. The output leaves the block as a data bus plus a drive-enable bit, so the core has no internal tri-states. A pad-level wrapper or the chip's I/O ring turns this pair into a three-state bus. The output enable gates only that drive-enable bit. Storage keeps running while the output is disabled.

Top module: `latch_reg_driver`

## Requirements
- R1: While reset is asserted, and on release, y_data is all zeros and y_oe is 0 (outputs disabled).
- R2: Once lat_en has been high for SYNC_STAGES system cycles, y_data equals a_in in the same cycle that a_in changes, with no capture-clock edge needed.
- R3: With lat_en low, a 0-to-1 transition on cap_clk loads a_in into storage. The value appears on y_data SYNC_STAGES+1 system cycles after the transition and stays there after a_in changes.
- R4: With lat_en low and cap_clk held at a steady level, y_data does not change whatever a_in does.
- R5: A 1-to-0 transition on cap_clk with lat_en low loads nothing, and y_data keeps its value.
- R6: When lat_en falls, storage keeps the last value that passed through in transparent mode until the next rising cap_clk edge. A rising edge seen in the same cycle as the fall loads a_in.
- R7: y_oe equals the inverse of oe_n as sampled SYNC_STAGES system cycles earlier, so oe_n low (value 0) enables the output and oe_n high disables it.
- R8: The output enable has no effect on storage. A value captured while y_oe is 0 shows on y_data at once and is still there after y_oe returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | WIDTH | Input data bus |
| cap_clk | input | 1 | Asynchronous capture clock, used on its rising edge |
| lat_en | input | 1 | Asynchronous mode select: 1 transparent, 0 edge register |
| oe_n | input | 1 | Asynchronous active-low output enable |
| y_data | output | WIDTH | Stored or transparent data |
| y_oe | output | 1 | Drive enable for the three-state wrapper, 1 drives |

## Verification
The bench builds the block with WIDTH=4 and the default two-stage synchronizer. The narrow bus makes it practical to sweep every input code through transparent mode and through edge capture, with the bus changed to the complement after each edge. Hold mode is checked while all sixteen codes stream past a steady capture clock. The default synchronizer depth keeps the control-to-output latencies short and fixed, so each check can be placed on the exact cycle the requirements name.

// File: rtl/latch_reg_driver.sv
module latch_reg_driver #(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic             cap_clk,
  input  logic             lat_en,
  input  logic             oe_n,
  output logic [WIDTH-1:0] y_data,
  output logic             y_oe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]      clk_sync, le_sync, oen_sync;
  logic               clk_prev;
  logic [WIDTH-1:0]   store;

  wire clk_s = clk_sync[LAST];
  wire le_s  = le_sync[LAST];
  wire rise  = clk_s & ~clk_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          clk_sync <= '0; le_sync <= '0; oen_sync <= '1;
        end else begin
          clk_sync <= cap_clk; le_sync <= lat_en; oen_sync <= oe_n;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          clk_sync <= '0; le_sync <= '0; oen_sync <= '1;
        end else begin
          clk_sync <= {clk_sync[LAST-1:0], cap_clk};
          le_sync  <= {le_sync[LAST-1:0],  lat_en};
          oen_sync <= {oen_sync[LAST-1:0], oe_n};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_prev <= 1'b0;
      store    <= '0;
    end else begin
      clk_prev <= clk_s;
      if (le_s || rise) store <= a_in;
    end

  assign y_data = le_s ? a_in : store;
  assign y_oe   = ~oen_sync[LAST];
endmodule

module latch_reg_driver_chk #(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic             oe_n,
  input logic [WIDTH-1:0] y_data,
  input logic             y_oe,
  input logic             le_s,
  input logic             clk_s,
  input logic             clk_prev,
  input logic [WIDTH-1:0] store
);
  logic [3:0] since;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since <= '0;
    else if (since != 4'hF) since <= since + 4'd1;

  p_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> (y_data == '0 && !y_oe));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_s && clk_s && !clk_prev) |=> (store == $past(a_in)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_s && !(clk_s && !clk_prev)) |=> $stable(store));

  p_le_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since > 4'd1 && $fell(le_s)) |-> (y_data == $past(a_in)));

  p_oe_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since > 4'd3 && SYNC_STAGES == 2) |-> (y_oe == !$past(oe_n, 2)));
endmodule

bind latch_reg_driver latch_reg_driver_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .oe_n(oe_n), .y_data(y_data), .y_oe(y_oe),
  .le_s(le_s), .clk_s(clk_s), .clk_prev(clk_prev), .store(store)
);

// File: tb/latch_reg_driver_tb.sv
module latch_reg_driver_tb;
  localparam int TCLK = 10;
  localparam int W    = 4;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_in = '0;
  logic         cap_clk = 1'b0, lat_en = 1'b0, oe_n = 1'b1;
  logic [W-1:0] y_data;
  logic         y_oe;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  latch_reg_driver #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .cap_clk(cap_clk), .lat_en(lat_en),
    .oe_n(oe_n), .y_data(y_data), .y_oe(y_oe)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(TCLK * 200000);
    total++; bad++;
    $display("FAIL watchdog: got 0 expected 1 (completion)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wn(3);
    chk("R1 data", y_data, 0);
    chk("R1 oe", y_oe, 0);
    rst_n = 1'b1;
    wn(1);
    chk("R1 data after release", y_data, 0);
    chk("R1 oe after release", y_oe, 0);

    oe_n = 1'b0;
    wn(1); chk("R7 oe after one cycle", y_oe, 0);
    wn(1); chk("R7 oe after two cycles", y_oe, 1);

    lat_en = 1'b1;
    wn(3);
    for (int v = 0; v < 16; v++) begin
      a_in = W'(v); #1;
      chk("R2 transparent", y_data, v);
      wn(1);
    end

    a_in = 4'd9; wn(1);
    lat_en = 1'b0; wn(3);
    a_in = 4'd5; wn(2);
    chk("R6 keeps last transparent value", y_data, 9);

    for (int v = 0; v < 16; v++) begin
      a_in = W'(v); cap_clk = 1'b1;
      wn(2); chk("R3 not yet loaded", y_data, (v + 15) % 16 == 15 && v == 0 ? 9 : (v + 15) % 16);
      wn(2);
      a_in = ~W'(v); wn(2);
      chk("R3 captured value", y_data, v);
      cap_clk = 1'b0; wn(4);
      chk("R5 falling edge ignored", y_data, v);
    end

    for (int v = 0; v < 16; v++) begin
      a_in = W'(v); wn(1);
      chk("R4 hold with cap_clk low", y_data, 15);
    end
    cap_clk = 1'b1; a_in = 4'd7; wn(4);
    for (int v = 0; v < 16; v++) begin
      a_in = W'(v); wn(1);
      chk("R4 hold with cap_clk high", y_data, 7);
    end
    cap_clk = 1'b0; wn(4);

    oe_n = 1'b1; wn(3);
    chk("R8 disabled", y_oe, 0);
    a_in = 4'hA; cap_clk = 1'b1; wn(4);
    a_in = 4'h3; wn(1);
    chk("R8 capture while disabled", y_data, 10);
    cap_clk = 1'b0; oe_n = 1'b0; wn(3);
    chk("R8 enabled again", y_oe, 1);
    chk("R8 value kept", y_data, 10);

    lat_en = 1'b1; a_in = 4'd6; wn(4);
    lat_en = 1'b0; cap_clk = 1'b1; wn(4);
    a_in = 4'd1; wn(2);
    chk("R6 edge with lat_en fall", y_data, 6);
    cap_clk = 1'b0; wn(4);
    chk("R6 held after edge", y_data, 6);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule